// File: doc/BRIEF.md
# Register-Programmable Sensor Logic Combiner

This block drives two digital output channels from touch-sensor status bits. Each channel has two byte-wide registers on a simple address/data bus. The operation register turns the combiner on, picks OR or AND as the operator, and can invert the result. The input-select register is a two-bit mask that names which sensor status bits take part in the combination.

While a channel's combiner is off, its output follows a fixed default status bit. Writes to a channel's operation register are dropped while that channel's pin-enable input is low. Writes to the input-select register are not gated. Both outputs are registered. Reset is synchronous and active-high.

Top module: `sense_logic_combiner`

## Requirements
- R1: On reset, both operation registers read 0x00, input-select reads 0x01 for channel 0 and 0x02 for channel 1, and both outputs are 0.
- R2: The operation registers sit at 0x1C (channel 0) and 0x21 (channel 1). The input-select registers sit at 0x1E (channel 0) and 0x23 (channel 1). A read returns the stored fields, and every unused bit reads as 0.
- R3: In an operation register, bit 7 enables the combiner, bit 1 inverts its result, and bit 0 selects the operator. In an input-select register, bits [1:0] form the mask, and mask bit k selects status bit k.
- R4: With the combiner enabled, the operator bit at 0 and a non-empty mask, the combined value is the OR of the selected status bits.
- R5: With the combiner enabled, the operator bit at 1 and a non-empty mask, the combined value is the AND of the selected status bits.
- R6: With the combiner enabled and an all-zero mask, the combined value is 0 before inversion.
- R7: When the invert bit is 1, the output is the complement of the combined value. When the invert bit is 0, the combined value passes unchanged.
- R8: While a channel's enable bit is 0, its output follows status bit 0 (channel 0) or status bit 1 (channel 1).
- R9: A write to a channel's operation register leaves that register unchanged while that channel's pin_en bit is 0. Input-select writes take effect regardless of pin_en.
- R10: A read from any address other than the four mapped ones returns 0x00.
- R11: Outputs update on the rising clock edge. A status change at the inputs appears at the outputs one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| pin_en | input | 2 | Per-channel output pin enable; gates operation-register writes |
| status | input | 2 | Sensor status bits |
| dout | output | 2 | Registered channel outputs |

## Verification
For each channel, the bench programs all eight combinations of enable, invert and operator and all four masks, then applies all four status patterns. The mask patterns separate OR from AND only where they can differ: a single-bit mask makes the two operators agree, and a full mask with mixed status makes them disagree. The empty mask exposes the forced-zero rule, and the invert and disabled cases show the complement and the default-bit path. Separate steps write with the pin disabled, sweep every address for reads, and sample one half-cycle after a status change to observe the one-cycle latency.

// File: rtl/sense_logic_combiner.sv
module sense_logic_combiner #(
  parameter logic [7:0] OP0_ADDR  = 8'h1C,
  parameter logic [7:0] OP1_ADDR  = 8'h21,
  parameter logic [7:0] SEL0_ADDR = 8'h1E,
  parameter logic [7:0] SEL1_ADDR = 8'h23
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [1:0] pin_en,
  input  logic [1:0] status,
  output logic [1:0] dout
);

  logic [1:0] en_q, inv_q, and_q;
  logic [1:0] sel0_q, sel1_q;
  logic [1:0] nxt;

  function automatic logic combine(logic [1:0] st, logic [1:0] m, logic use_and, logic inv);
    logic r;
    if (m == 2'b00)   r = 1'b0;
    else if (use_and) r = &(st | ~m);
    else              r = |(st & m);
    return r ^ inv;
  endfunction

  assign nxt[0] = en_q[0] ? combine(status, sel0_q, and_q[0], inv_q[0]) : status[0];
  assign nxt[1] = en_q[1] ? combine(status, sel1_q, and_q[1], inv_q[1]) : status[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      inv_q  <= '0;
      and_q  <= '0;
      sel0_q <= 2'b01;
      sel1_q <= 2'b10;
      dout   <= '0;
    end else begin
      if (we) begin
        if (addr == OP0_ADDR && pin_en[0]) begin
          en_q[0]  <= wdata[7];
          inv_q[0] <= wdata[1];
          and_q[0] <= wdata[0];
        end
        if (addr == OP1_ADDR && pin_en[1]) begin
          en_q[1]  <= wdata[7];
          inv_q[1] <= wdata[1];
          and_q[1] <= wdata[0];
        end
        if (addr == SEL0_ADDR) sel0_q <= wdata[1:0];
        if (addr == SEL1_ADDR) sel1_q <= wdata[1:0];
      end
      dout <= nxt;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr == OP0_ADDR)       rdata = {en_q[0], 5'b0, inv_q[0], and_q[0]};
    else if (addr == OP1_ADDR)  rdata = {en_q[1], 5'b0, inv_q[1], and_q[1]};
    else if (addr == SEL0_ADDR) rdata = {6'b0, sel0_q};
    else if (addr == SEL1_ADDR) rdata = {6'b0, sel1_q};
  end

endmodule

// File: rtl/slc_checker.sv
module slc_checker (
  input logic       clk,
  input logic       rst,
  input logic       we,
  input logic [7:0] addr,
  input logic [7:0] rdata,
  input logic [1:0] pin_en,
  input logic [1:0] status,
  input logic [1:0] dout,
  input logic [1:0] en_q,
  input logic [1:0] inv_q,
  input logic [1:0] and_q,
  input logic [1:0] sel0_q,
  input logic [1:0] sel1_q
);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_q == 2'b00 && inv_q == 2'b00 && and_q == 2'b00 &&
                    sel0_q == 2'b01 && sel1_q == 2'b10 && dout == 2'b00));

  p_op0_gated_r9: assert property (@(posedge clk) disable iff (rst)
    (we && addr == 8'h1C && !pin_en[0]) |=> $stable({en_q[0], inv_q[0], and_q[0]}));

  p_op1_gated_r9: assert property (@(posedge clk) disable iff (rst)
    (we && addr == 8'h21 && !pin_en[1]) |=> $stable({en_q[1], inv_q[1], and_q[1]}));

  p_default0_r8: assert property (@(posedge clk) disable iff (rst)
    !en_q[0] |=> dout[0] == $past(status[0]));

  p_default1_r8: assert property (@(posedge clk) disable iff (rst)
    !en_q[1] |=> dout[1] == $past(status[1]));

  p_empty_mask0_r6: assert property (@(posedge clk) disable iff (rst)
    (en_q[0] && sel0_q == 2'b00) |=> dout[0] == $past(inv_q[0]));

  p_empty_mask1_r6: assert property (@(posedge clk) disable iff (rst)
    (en_q[1] && sel1_q == 2'b00) |=> dout[1] == $past(inv_q[1]));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !(addr == 8'h1C || addr == 8'h21 || addr == 8'h1E || addr == 8'h23) |-> rdata == 8'h00);

endmodule

bind sense_logic_combiner slc_checker chk (
  .clk(clk), .rst(rst), .we(we), .addr(addr), .rdata(rdata),
  .pin_en(pin_en), .status(status), .dout(dout),
  .en_q(en_q), .inv_q(inv_q), .and_q(and_q), .sel0_q(sel0_q), .sel1_q(sel1_q)
);

// File: tb/sense_logic_combiner_test.sv
module sense_logic_combiner_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       we = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [1:0] pin_en = 2'b11;
  logic [1:0] status = 2'b00;
  logic [1:0] dout;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sense_logic_combiner uut (
    .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pin_en(pin_en), .status(status), .dout(dout)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_check(string tag, logic [7:0] a, logic [7:0] exp);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  function automatic logic expect_out(int ch, logic en, logic inv, logic op,
                                      logic [1:0] m, logic [1:0] st);
    logic r;
    if (!en) return st[ch];
    if (m == 2'b00) r = 1'b0;
    else if (op)    r = ((st & m) == m);
    else            r = ((st & m) != 2'b00);
    return r ^ inv;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    rd_check("R1 op0", 8'h1C, 8'h00);
    rd_check("R1 op1", 8'h21, 8'h00);
    rd_check("R1 sel0", 8'h1E, 8'h01);
    rd_check("R1 sel1", 8'h23, 8'h02);
    check("R1 dout", {6'b0, dout}, 8'h00);

    for (int ch = 0; ch < 2; ch++) begin
      for (int cfg = 0; cfg < 8; cfg++) begin
        for (int m = 0; m < 4; m++) begin
          logic en, inv, op;
          logic [7:0] opa, sela;
          en = cfg[2]; inv = cfg[1]; op = cfg[0];
          opa  = (ch == 0) ? 8'h1C : 8'h21;
          sela = (ch == 0) ? 8'h1E : 8'h23;
          wr(opa, {en, 5'b10101, inv, op});
          wr(sela, {6'b111011, m[1:0]});
          rd_check("R2 R3 op readback", opa, {en, 5'b0, inv, op});
          rd_check("R2 R3 sel readback", sela, {6'b0, m[1:0]});
          for (int st = 0; st < 4; st++) begin
            string tag;
            @(negedge clk);
            status = st[1:0];
            @(negedge clk);
            if (!en) tag = "R8 default path";
            else if (m == 0) tag = "R6 empty mask";
            else if (inv) tag = "R7 invert";
            else if (op) tag = "R5 AND";
            else tag = "R4 OR";
            check(tag, {7'b0, dout[ch]},
                  {7'b0, expect_out(ch, en, inv, op, m[1:0], st[1:0])});
          end
        end
      end
    end

    // R11 latency: channel 0 OR over bit 0, channel 1 disabled
    wr(8'h1C, 8'h80);
    wr(8'h1E, 8'h01);
    wr(8'h21, 8'h00);
    @(negedge clk);
    status = 2'b00;
    @(negedge clk);
    check("R11 settled", {6'b0, dout}, 8'h00);
    status = 2'b11;
    #1;
    check("R11 before edge", {6'b0, dout}, 8'h00);
    @(negedge clk);
    check("R11 after edge", {6'b0, dout}, 8'h03);

    // R9 write gating
    pin_en = 2'b00;
    wr(8'h1C, 8'h83);
    wr(8'h21, 8'h82);
    rd_check("R9 op0 gated", 8'h1C, 8'h80);
    rd_check("R9 op1 gated", 8'h21, 8'h00);
    wr(8'h1E, 8'h03);
    wr(8'h23, 8'h00);
    rd_check("R9 sel0 ungated", 8'h1E, 8'h03);
    rd_check("R9 sel1 ungated", 8'h23, 8'h00);
    pin_en = 2'b10;
    wr(8'h21, 8'h82);
    rd_check("R9 op1 enabled write", 8'h21, 8'h82);
    wr(8'h1C, 8'h01);
    rd_check("R9 op0 still gated", 8'h1C, 8'h80);

    // R10 unmapped reads
    for (int a = 0; a < 256; a++) begin
      if (a != 'h1C && a != 'h21 && a != 'h1E && a != 'h23)
        rd_check("R10 unmapped", a[7:0], 8'h00);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule